// File: doc/BRIEF.md
# Static Twelve-Segment LCD Driver

This block drives a directly wired (non-multiplexed) liquid crystal display made of twelve independent segments and a single common electrode. A free-running counter divides the system clock into a square wave with a 50% duty cycle. This wave drives the common (backplane) output. With the default divider and a 4.096 MHz clock, the backplane runs at 62.5 Hz.

Each segment output is a copy of the backplane or its inverse, chosen by the segment's enable bit. A segment whose output is in phase with the backplane sees no voltage and stays dark. A segment driven in antiphase sees a full alternating voltage and turns dark-visible, which means "on". In both cases the voltage across the glass averages to zero, so the panel never carries DC.

The host sets the enable bits through a simple write port that reaches two 8-bit registers. The low register holds segments 0 to 7. The high register holds segments 8 to 11 in its low nibble.

Top module: `lcd_static_drv`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the backplane output is 0, every segment output is 0, and all twelve enable bits are cleared.
- R2: The backplane inverts once every HALF_PERIOD clock cycles, giving a 50% duty square wave. The default HALF_PERIOD is 32768, which gives 62.5 Hz from 4.096 MHz.
- R3: The backplane keeps toggling at the same rate whatever the write port is doing.
- R4: A segment whose enable bit is 0 outputs exactly the backplane level.
- R5: A segment whose enable bit is 1 outputs the inverse of the backplane level.
- R6: A write to address 0x12 loads data bits 7:0 into the enables of segments 7:0, with bit n going to segment n.
- R7: A write to address 0x13 loads data bits 3:0 into the enables of segments 11:8, with bit n going to segment 8+n. Data bits 7:4 have no effect.
- R8: A write to any other address changes no enable bit.
- R9: Segment outputs change on the same clock edge as the backplane. A write is visible at the segment outputs from the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (4.096 MHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| bp | output | 1 | Backplane (common) square wave |
| seg | output | 12 | Segment drive outputs |

## Verification
A wrong enable bit shows up at once as a segment that matches the backplane when it should oppose it, or the other way round. It is visible on the first sampled cycle after the faulty write, in either backplane phase. A divider fault shows up as a wrong count of cycles between backplane edges within the first period. A misaligned output register shows up as a one-cycle glitch where a segment disagrees with the backplane right at a backplane edge. Sweeping every cycle of a full period catches that glitch.

// File: rtl/lcd_pkg.sv
// Package: shared constants for the static LCD driver.
// Assumes a byte-wide register port; segment count is fixed by the panel.
package lcd_pkg;
    localparam int SEG_COUNT  = 12;
    localparam int REG_W      = 8;
    localparam int ADDR_W     = 8;
    localparam logic [ADDR_W-1:0] SEG_BASE_ADDR = 8'h12;
endpackage

// File: rtl/lcd_bp_gen.sv
// Module: lcd_bp_gen
// Divides the clock into a 50% duty square wave for the LCD common electrode.
// Exposes the next-state value so downstream registers switch on the same edge.
// Assumes HALF_PERIOD >= 2.
module lcd_bp_gen #(
    parameter int HALF_PERIOD = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic bp_q,
    output logic bp_d
);
    localparam int CNT_W = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    // Detect the last cycle of a half period.
    always_comb wrap = (cnt == CNT_LAST);

    // Next backplane level, shared with the segment output stage.
    always_comb bp_d = wrap ? ~bp_q : bp_q;

    // Half-period counter and backplane register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            bp_q <= 1'b0;
        end else begin
            cnt  <= wrap ? '0 : cnt + 1'b1;
            bp_q <= bp_d;
        end
    end

    // R2
    bp_min_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_q != $past(bp_q)) |=> $stable(bp_q));
endmodule

// File: rtl/lcd_seg_regs.sv
// Module: lcd_seg_regs
// Holds the segment enable bits behind a byte-wide write port. Segment i sits
// in register i/REG_W at bit i%REG_W; data bits beyond the last segment are dropped.
// Assumes one write per cycle at most.
module lcd_seg_regs
    import lcd_pkg::*;
#(
    parameter int NSEG = SEG_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [NSEG-1:0]   en_q,
    output logic [NSEG-1:0]   en_d
);
    localparam int NREGS = (NSEG + REG_W - 1) / REG_W;

    logic [NREGS-1:0] hit;

    // Decode which enable register, if any, the write targets.
    generate
        for (genvar r = 0; r < NREGS; r++) begin : g_dec
            assign hit[r] = wr_en && (wr_addr == SEG_BASE_ADDR + ADDR_W'(r));
        end
    endgenerate

    // Next enable value: load the addressed bits, hold the rest.
    always_comb begin
        for (int i = 0; i < NSEG; i++) begin
            en_d[i] = hit[i / REG_W] ? wr_data[i % REG_W] : en_q[i];
        end
    end

    // Enable register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // R8
    foreign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (hit == '0)) |=> $stable(en_q));
endmodule

// File: rtl/lcd_seg_out.sv
// Module: lcd_seg_out
// Registers each segment drive as backplane XOR enable, using next-state inputs
// so segment and backplane edges coincide.
// Assumes bp_d and en_d are the next values of the registered backplane and enables.
module lcd_seg_out #(
    parameter int NSEG = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bp_d,
    input  logic [NSEG-1:0] en_d,
    output logic [NSEG-1:0] seg_q
);
    // Phase-select register per segment.
    always_ff @(posedge clk) begin
        if (!rst_n) seg_q <= '0;
        else        seg_q <= en_d ^ {NSEG{bp_d}};
    end
endmodule

// File: rtl/lcd_static_drv.sv
// Module: lcd_static_drv (top)
// Static twelve-segment LCD driver: backplane divider, enable registers and
// phase-select outputs. Assumes HALF_PERIOD >= 2 and a synchronous reset.
module lcd_static_drv
    import lcd_pkg::*;
#(
    parameter int HALF_PERIOD = 32768
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    output logic                 bp,
    output logic [SEG_COUNT-1:0] seg
);
    logic                 bp_next;
    logic [SEG_COUNT-1:0] en_cur;
    logic [SEG_COUNT-1:0] en_next;

    lcd_bp_gen #(.HALF_PERIOD(HALF_PERIOD)) u_bp (
        .clk(clk), .rst_n(rst_n), .bp_q(bp), .bp_d(bp_next)
    );

    lcd_seg_regs #(.NSEG(SEG_COUNT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en_q(en_cur), .en_d(en_next)
    );

    lcd_seg_out #(.NSEG(SEG_COUNT)) u_out (
        .clk(clk), .rst_n(rst_n), .bp_d(bp_next), .en_d(en_next), .seg_q(seg)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (bp == 1'b0 && seg == '0 && en_cur == '0));

    // R4 R5 R9
    phase_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg ^ {SEG_COUNT{bp}}) == en_cur);
endmodule

// File: tb/tb_lcd_static_drv.sv
module tb_lcd_static_drv;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam int WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic        bp;
    logic [11:0] seg;

    logic [11:0] model_en = '0;
    int checks = 0;
    int errors = 0;

    lcd_static_drv #(.HALF_PERIOD(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bp(bp), .seg(seg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (a == 8'h12) model_en[7:0] = d;
        else if (a == 8'h13) model_en[11:8] = d[3:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Check segments against the model for every cycle of one full period.
    task automatic sweep(input string req);
        for (int k = 0; k < 2*HALF; k++) begin
            chk(req, {20'd0, seg}, {20'd0, model_en ^ {12{bp}}});
            @(negedge clk);
        end
    endtask

    task automatic t_reset(input string req);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        model_en = '0;
        chk({req, " bp"}, {31'd0, bp}, 32'd0);
        chk({req, " seg"}, {20'd0, seg}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({req, " seg after release"}, {20'd0, seg}, 32'd0);
    endtask

    // R2: cycles between backplane edges, both phases
    task automatic t_period();
        logic prev;
        int n;
        prev = bp;
        while (bp == prev) @(negedge clk);
        for (int e = 0; e < 2; e++) begin
            prev = bp; n = 0;
            while (bp == prev) begin @(negedge clk); n++; end
            chk("R2 half period", n, HALF);
        end
    endtask

    // R3: backplane toggle count during continuous writes
    task automatic t_run_during_writes();
        logic prev;
        int tog = 0;
        @(negedge clk);
        prev = bp;
        wr_en = 1'b1; wr_addr = 8'h12;
        for (int k = 0; k < 4*HALF; k++) begin
            wr_data = 8'(k);
            model_en[7:0] = 8'(k);
            @(negedge clk);
            if (bp != prev) tog++;
            prev = bp;
        end
        wr_en = 1'b0;
        chk("R3 toggles under writes", tog, 4);
    endtask

    task automatic t_low_reg();
        write_reg(8'h12, 8'hA5);
        chk("R6 low reg visible", {20'd0, seg}, {20'd0, model_en ^ {12{bp}}});
        sweep("R4 R5 R6 R9 low reg sweep");
    endtask

    task automatic t_high_reg();
        write_reg(8'h13, 8'hF6);
        chk("R7 upper nibble ignored", {20'd0, seg[11:8] ^ {4{bp}}}, 32'h6);
        sweep("R7 R9 high reg sweep");
    endtask

    task automatic t_foreign();
        write_reg(8'h14, 8'hFF);
        write_reg(8'h11, 8'hFF);
        write_reg(8'h92, 8'hFF);
        chk("R8 foreign address", {20'd0, seg ^ {12{bp}}}, {20'd0, model_en});
        sweep("R8 foreign sweep");
    endtask

    task automatic t_all_on_off();
        write_reg(8'h12, 8'hFF); write_reg(8'h13, 8'h0F);
        sweep("R5 all on");
        chk("R5 all on inverse", {20'd0, seg}, {20'd0, ~{12{bp}}});
        write_reg(8'h12, 8'h00); write_reg(8'h13, 8'h00);
        sweep("R4 all off");
        chk("R4 all off in phase", {20'd0, seg}, {20'd0, {12{bp}}});
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset("R1");
        sweep("R1 R4 blank after reset");
        t_period();
        t_low_reg();
        t_high_reg();
        t_foreign();
        t_all_on_off();
        t_run_during_writes();
        sweep("R3 R9 after write burst");
        write_reg(8'h13, 8'h05);
        t_reset("R1 mid-run");
        sweep("R1 cleared enables");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule